// File: doc/BRIEF.md
# Address-Event Remap Table with Neighbour Swaps

This block sits in a spike-routing path and translates the address of each incoming presynaptic event into the address of the synaptic site that source currently feeds. The translation is a one-to-one table over a fixed grid of sites. Sources and sites have the same count, so every site always has exactly one owner. Only the wiring is held here. No weight is stored anywhere.

A migration request names the site a terminal occupies now and the site it wants to move to. The block looks up which source owns each of the two sites. It then exchanges them, so both sources move and no site is ever empty or doubly owned. A forward table (source to site) and an inverse table (site to source) are kept and rewritten together in one cycle. Event routing pauses while an exchange is in flight, so no routed event ever sees a half-written mapping.

A load port writes single pairs to build an initial mapping. An audit output reports whenever the two tables stop being exact inverses of each other.

Top module: `ae_remap`

## Requirements
- R1: After reset the mapping is the identity. An event with source index below N_SITES that is accepted (`spk_valid` and `spk_ready`) produces `out_valid` one cycle later, with `out_site` equal to the site that source owns under the mapping at acceptance.
- R2: An event whose source index is N_SITES or more produces no `out_valid`.
- R3: An accepted exchange with distinct in-range sites `swp_cur` and `swp_dst` moves the owner of `swp_cur` to `swp_dst` and the owner of `swp_dst` to `swp_cur`. Every later event follows the new mapping.
- R4: An accepted exchange keeps `spk_ready` and `swp_ready` low for exactly the two cycles after acceptance. No event is routed in those cycles.
- R5: An exchange request with equal sites, or with either site at N_SITES or more, is dropped. The block does not go busy and the mapping is unchanged.
- R6: Exchanges keep the forward and inverse tables mutual inverses, so `table_err` stays low through any number of exchanges.
- R7: A load (`ld_valid` with both indices in range) writes the forward entry of `ld_src` to `ld_site` and the inverse entry of `ld_site` to `ld_src`. A load presented while an exchange is busy is ignored.
- R8: `table_err` goes high one cycle after the tables disagree at any source, and it returns low one cycle after they agree again. It is low after reset.
- R9: `swp_ready` is low in any cycle in which `ld_valid` is high, so a load always wins over an exchange request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spk_valid | input | 1 | Incoming event present |
| spk_src | input | AW | Source index of the incoming event |
| spk_ready | output | 1 | High when an event can be accepted (no exchange in flight) |
| out_valid | output | 1 | Routed event present |
| out_site | output | AW | Target site of the routed event |
| swp_valid | input | 1 | Exchange request present |
| swp_cur | input | AW | Site currently occupied by the requesting terminal |
| swp_dst | input | AW | Neighbouring site the terminal wants to occupy |
| swp_ready | output | 1 | High when an exchange request can be accepted |
| ld_valid | input | 1 | Load one mapping pair |
| ld_src | input | AW | Source index to load |
| ld_site | input | AW | Site index to load |
| table_err | output | 1 | Forward and inverse tables disagree |

## Verification
A corrupted forward entry appears as a wrong `out_site` on the next event from that source, one cycle after acceptance. A corrupted inverse entry stays hidden until an exchange touches that site and moves the wrong owner. The audit output reports it one cycle after the write, before any event can use it. A broken stall shows up as an event routed through the old mapping during the two busy cycles. The bench therefore routes events from both swapped sources after every exchange, and it holds an event against a busy block to see which mapping it finally uses.

// File: rtl/remap_pkg.sv
// Package: shared types for the address-event remap table.
// Assumes nothing beyond IEEE 1800-2017 enums.
package remap_pkg;

    // Phases of one exchange: idle, owner lookup, table write.
    typedef enum logic [1:0] {
        SW_IDLE  = 2'd0,
        SW_READ  = 2'd1,
        SW_WRITE = 2'd2
    } swap_state_t;

endpackage

// File: rtl/remap_tables.sv
// Module: remap_tables
// Holds the forward (source -> site) and inverse (site -> source) tables.
// Reset loads the identity mapping. A load writes one pair. An exchange
// writes two forward and two inverse entries in the same cycle.
// Assumes the caller never raises both write strobes together and only
// presents in-range indices.
module remap_tables #(
    parameter int N_SITES = 15,
    parameter int AW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_site,
    input  logic          sw_we,
    input  logic [AW-1:0] sw_cur,
    input  logic [AW-1:0] sw_dst,
    input  logic [AW-1:0] sw_own_cur,
    input  logic [AW-1:0] sw_own_dst,
    output logic [AW-1:0] fwd_tab [N_SITES],
    output logic [AW-1:0] inv_tab [N_SITES]
);

    // Table storage: identity on reset, then load or exchange writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SITES; i++) begin
                fwd_tab[i] <= AW'(i);
                inv_tab[i] <= AW'(i);
            end
        end else if (ld_we) begin
            fwd_tab[ld_src]  <= ld_site;
            inv_tab[ld_site] <= ld_src;
        end else if (sw_we) begin
            fwd_tab[sw_own_cur] <= sw_dst;
            fwd_tab[sw_own_dst] <= sw_cur;
            inv_tab[sw_cur]     <= sw_own_dst;
            inv_tab[sw_dst]     <= sw_own_cur;
        end
    end

    // R7: the load path and the exchange path never write together.
    assert_single_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_we && sw_we));

endmodule

// File: rtl/remap_swap_ctrl.sv
// Module: remap_swap_ctrl
// Sequences one exchange: accept and validate the request, read both
// owners from the inverse table, then strobe the four-entry write.
// Assumes req_valid is only high when the top-level handshake completes.
module remap_swap_ctrl
    import remap_pkg::*;
#(
    parameter int N_SITES = 15,
    parameter int AW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_cur,
    input  logic [AW-1:0] req_dst,
    input  logic [AW-1:0] owner_of_cur,
    input  logic [AW-1:0] owner_of_dst,
    output logic          busy,
    output logic          sw_we,
    output logic [AW-1:0] cur_q,
    output logic [AW-1:0] dst_q,
    output logic [AW-1:0] own_cur_q,
    output logic [AW-1:0] own_dst_q
);

    localparam logic [AW:0] SITE_LIM = (AW+1)'(N_SITES);

    swap_state_t state, state_nx;
    logic        req_ok;

    // Request is usable only for two distinct sites inside the array.
    assign req_ok = (req_cur != req_dst)
                 && ({1'b0, req_cur} < SITE_LIM)
                 && ({1'b0, req_dst} < SITE_LIM);

    // Next-state selection for the three-phase exchange.
    always_comb begin
        state_nx = state;
        case (state)
            SW_IDLE:  if (req_valid && req_ok) state_nx = SW_READ;
            SW_READ:  state_nx = SW_WRITE;
            SW_WRITE: state_nx = SW_IDLE;
            default:  state_nx = SW_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SW_IDLE;
        else        state <= state_nx;
    end

    // Capture the site pair on acceptance and both owners in the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q     <= '0;
            dst_q     <= '0;
            own_cur_q <= '0;
            own_dst_q <= '0;
        end else if (state == SW_IDLE && req_valid && req_ok) begin
            cur_q <= req_cur;
            dst_q <= req_dst;
        end else if (state == SW_READ) begin
            own_cur_q <= owner_of_cur;
            own_dst_q <= owner_of_dst;
        end
    end

    assign busy  = (state != SW_IDLE);
    assign sw_we = (state == SW_WRITE);

    // R4: once busy, stay busy one more cycle, then return to idle.
    assert_fixed_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy ##1 !busy);

    // R5: a malformed request never starts an exchange.
    assert_drop_bad_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_ok) |=> !busy);

endmodule

// File: rtl/remap_audit.sv
// Module: remap_audit
// Compares every forward entry against the inverse table in parallel and
// registers the result as the error flag.
// Assumes both tables have N_SITES entries of AW bits.
module remap_audit #(
    parameter int N_SITES = 15,
    parameter int AW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] fwd_tab [N_SITES],
    input  logic [AW-1:0] inv_tab [N_SITES],
    output logic          mismatch,
    output logic          table_err
);

    localparam logic [AW:0] SITE_LIM = (AW+1)'(N_SITES);

    logic [N_SITES-1:0] bad;

    // One comparator per source: its site must exist and point back to it.
    for (genvar g = 0; g < N_SITES; g++) begin : g_cmp
        localparam logic [AW-1:0] IDX = AW'(g);
        assign bad[g] = ({1'b0, fwd_tab[g]} >= SITE_LIM)
                     || (inv_tab[fwd_tab[g]] != IDX);
    end

    assign mismatch = |bad;

    // Registered error flag, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) table_err <= 1'b0;
        else        table_err <= mismatch;
    end

endmodule

// File: rtl/ae_remap.sv
// Module: ae_remap (top)
// Routes source addresses to synaptic sites through a permutation table,
// applies neighbour exchanges atomically, accepts single-pair loads and
// flags any forward/inverse disagreement.
// Assumes the output consumer is always ready; routing stalls only for
// exchanges.
module ae_remap #(
    parameter int N_COLS  = 5,
    parameter int N_ROWS  = 3,
    parameter int N_SITES = N_COLS * N_ROWS,
    parameter int AW      = $clog2(N_SITES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spk_valid,
    input  logic [AW-1:0] spk_src,
    output logic          spk_ready,
    output logic          out_valid,
    output logic [AW-1:0] out_site,
    input  logic          swp_valid,
    input  logic [AW-1:0] swp_cur,
    input  logic [AW-1:0] swp_dst,
    output logic          swp_ready,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_src,
    input  logic [AW-1:0] ld_site,
    output logic          table_err
);

    localparam logic [AW:0] SITE_LIM = (AW+1)'(N_SITES);

    logic [AW-1:0] fwd_tab [N_SITES];
    logic [AW-1:0] inv_tab [N_SITES];
    logic          busy, sw_we, ld_we, spk_take, mismatch;
    logic [AW-1:0] cur_q, dst_q, own_cur_q, own_dst_q;

    assign spk_ready = !busy;
    assign swp_ready = !busy && !ld_valid;
    assign ld_we     = ld_valid && !busy
                    && ({1'b0, ld_src} < SITE_LIM)
                    && ({1'b0, ld_site} < SITE_LIM);
    assign spk_take  = spk_valid && spk_ready && ({1'b0, spk_src} < SITE_LIM);

    remap_tables #(.N_SITES(N_SITES), .AW(AW)) u_tables (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_we      (ld_we),
        .ld_src     (ld_src),
        .ld_site    (ld_site),
        .sw_we      (sw_we),
        .sw_cur     (cur_q),
        .sw_dst     (dst_q),
        .sw_own_cur (own_cur_q),
        .sw_own_dst (own_dst_q),
        .fwd_tab    (fwd_tab),
        .inv_tab    (inv_tab)
    );

    remap_swap_ctrl #(.N_SITES(N_SITES), .AW(AW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (swp_valid && swp_ready),
        .req_cur      (swp_cur),
        .req_dst      (swp_dst),
        .owner_of_cur (inv_tab[cur_q]),
        .owner_of_dst (inv_tab[dst_q]),
        .busy         (busy),
        .sw_we        (sw_we),
        .cur_q        (cur_q),
        .dst_q        (dst_q),
        .own_cur_q    (own_cur_q),
        .own_dst_q    (own_dst_q)
    );

    remap_audit #(.N_SITES(N_SITES), .AW(AW)) u_audit (
        .clk       (clk),
        .rst_n     (rst_n),
        .fwd_tab   (fwd_tab),
        .inv_tab   (inv_tab),
        .mismatch  (mismatch),
        .table_err (table_err)
    );

    // Routing stage: one register between accepted event and routed output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_site  <= '0;
        end else begin
            out_valid <= spk_take;
            if (spk_take) out_site <= fwd_tab[spk_src];
        end
    end

    // R1: a routed event always names a real site.
    assert_site_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({1'b0, out_site} < SITE_LIM));

    // R2: an out-of-range source is never routed.
    assert_drop_bad_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (spk_valid && ({1'b0, spk_src} >= SITE_LIM)) |=> !out_valid);

    // R4: nothing is routed right after a busy cycle.
    assert_no_route_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !out_valid);

    // R6: an exchange applied to consistent tables leaves them consistent.
    assert_swap_keeps_inverse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_we && !mismatch) |=> !mismatch);

endmodule

// File: tb/ae_remap_test.sv
`timescale 1ns/1ps
// Bench for ae_remap: vector walk of events and exchanges, then directed
// tests for stalls, loads, audit flag and load priority.
module ae_remap_test;

    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          spk_valid, swp_valid, ld_valid;
    logic [AW-1:0] spk_src, swp_cur, swp_dst, ld_src, ld_site;
    logic          spk_ready, out_valid, swp_ready, table_err;
    logic [AW-1:0] out_site;

    int  n_total = 0;
    int  n_fail  = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    ae_remap uut (
        .clk(clk), .rst_n(rst_n),
        .spk_valid(spk_valid), .spk_src(spk_src), .spk_ready(spk_ready),
        .out_valid(out_valid), .out_site(out_site),
        .swp_valid(swp_valid), .swp_cur(swp_cur), .swp_dst(swp_dst),
        .swp_ready(swp_ready),
        .ld_valid(ld_valid), .ld_src(ld_src), .ld_site(ld_site),
        .table_err(table_err)
    );

    // Ops: 0 event routed, 1 exchange taken, 2 exchange dropped, 3 event dropped.
    // Fields: [13:12] op, [11:8] a, [7:4] b, [3:0] expected site.
    localparam logic [13:0] VEC [16] = '{
        {2'd0, 4'd3,  4'd0,  4'd3},
        {2'd1, 4'd3,  4'd4,  4'd0},
        {2'd0, 4'd3,  4'd0,  4'd4},
        {2'd0, 4'd4,  4'd0,  4'd3},
        {2'd1, 4'd4,  4'd9,  4'd0},
        {2'd0, 4'd3,  4'd0,  4'd9},
        {2'd0, 4'd9,  4'd0,  4'd4},
        {2'd0, 4'd4,  4'd0,  4'd3},
        {2'd2, 4'd5,  4'd5,  4'd0},
        {2'd0, 4'd5,  4'd0,  4'd5},
        {2'd2, 4'd2,  4'd15, 4'd0},
        {2'd0, 4'd2,  4'd0,  4'd2},
        {2'd1, 4'd0,  4'd14, 4'd0},
        {2'd0, 4'd0,  4'd0,  4'd14},
        {2'd0, 4'd14, 4'd0,  4'd0},
        {2'd3, 4'd15, 4'd0,  4'd0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0; spk_valid = 0; swp_valid = 0; ld_valid = 0;
        spk_src = '0; swp_cur = '0; swp_dst = '0; ld_src = '0; ld_site = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Present one event at a negedge, sample the routed result one cycle on.
    task automatic send_spike(input logic [AW-1:0] src, output logic ov, output logic [AW-1:0] site);
        spk_valid = 1'b1; spk_src = src;
        @(posedge clk);
        @(negedge clk);
        ov = out_valid; site = out_site;
        spk_valid = 1'b0;
    endtask

    // Present one exchange; report whether the block went busy, then wait idle.
    task automatic send_swap(input logic [AW-1:0] c, input logic [AW-1:0] d, output logic went_busy);
        swp_valid = 1'b1; swp_cur = c; swp_dst = d;
        @(posedge clk);
        @(negedge clk);
        swp_valid = 1'b0;
        went_busy = !spk_ready;
        while (!spk_ready) @(negedge clk);
    endtask

    task automatic send_load(input logic [AW-1:0] s, input logic [AW-1:0] t);
        ld_valid = 1'b1; ld_src = s; ld_site = t;
        @(posedge clk);
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_total++; n_fail++;
            $display("FAIL R4 watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        logic          ov, bz;
        logic [AW-1:0] st;

        apply_reset();
        // R8 and R1: reset state.
        chk(out_valid == 0, "R1 reset out_valid", out_valid, 0);
        chk(table_err == 0, "R8 reset table_err", table_err, 0);
        chk(spk_ready == 1 && swp_ready == 1, "R4 reset readies", {spk_ready, swp_ready}, 3);

        // Vector walk (R1, R2, R3, R5, R6).
        for (int i = 0; i < 16; i++) begin
            logic [13:0] v;
            v = VEC[i];
            case (v[13:12])
                2'd0: begin
                    send_spike(v[11:8], ov, st);
                    chk(ov == 1 && st == v[3:0], $sformatf("R1/R3 vec%0d site", i), st, v[3:0]);
                end
                2'd1: begin
                    send_swap(v[11:8], v[7:4], bz);
                    chk(bz == 1, $sformatf("R3 vec%0d busy", i), bz, 1);
                    @(negedge clk);
                    chk(table_err == 0, $sformatf("R6 vec%0d table_err", i), table_err, 0);
                end
                2'd2: begin
                    send_swap(v[11:8], v[7:4], bz);
                    chk(bz == 0, $sformatf("R5 vec%0d dropped", i), bz, 0);
                end
                default: begin
                    send_spike(v[11:8], ov, st);
                    chk(ov == 0, $sformatf("R2 vec%0d no output", i), ov, 0);
                end
            endcase
        end

        // R4: event held against a busy block uses the post-exchange mapping.
        swp_valid = 1'b1; swp_cur = 4'd6; swp_dst = 4'd7;
        @(posedge clk);
        @(negedge clk);
        swp_valid = 1'b0;
        chk(spk_ready == 0 && swp_ready == 0, "R4 busy cycle 1", {spk_ready, swp_ready}, 0);
        spk_valid = 1'b1; spk_src = 4'd6;
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 0 && spk_ready == 0, "R4 busy cycle 2", {out_valid, spk_ready}, 0);
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 0 && spk_ready == 1, "R4 idle after two", {out_valid, spk_ready}, 1);
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1 && out_site == 4'd7, "R4/R3 stalled event site", out_site, 7);
        spk_valid = 1'b0;
        send_spike(4'd7, ov, st);
        chk(ov == 1 && st == 4'd6, "R3 partner moved", st, 6);

        // Fresh start: identity again.
        apply_reset();
        send_spike(4'd3, ov, st);
        chk(ov == 1 && st == 4'd3, "R1 identity after reset", st, 3);

        // R7/R8: half a load breaks consistency, the second half restores it.
        send_load(4'd1, 4'd7);
        @(negedge clk);
        chk(table_err == 1, "R8 partial load flagged", table_err, 1);
        send_load(4'd7, 4'd1);
        @(negedge clk);
        chk(table_err == 0, "R8 complete load clears", table_err, 0);
        send_spike(4'd1, ov, st);
        chk(ov == 1 && st == 4'd7, "R7 loaded entry src1", st, 7);
        send_spike(4'd7, ov, st);
        chk(ov == 1 && st == 4'd1, "R7 loaded entry src7", st, 1);

        // R7: a load during a busy exchange is ignored.
        swp_valid = 1'b1; swp_cur = 4'd2; swp_dst = 4'd3;
        @(posedge clk);
        @(negedge clk);
        swp_valid = 1'b0;
        ld_valid = 1'b1; ld_src = 4'd4; ld_site = 4'd9;
        @(posedge clk);
        @(negedge clk);
        ld_valid = 1'b0;
        while (!spk_ready) @(negedge clk);
        @(negedge clk);
        chk(table_err == 0, "R7 busy load left tables consistent", table_err, 0);
        send_spike(4'd4, ov, st);
        chk(ov == 1 && st == 4'd4, "R7 busy load ignored", st, 4);
        send_spike(4'd2, ov, st);
        chk(ov == 1 && st == 4'd3, "R3 swap beside load", st, 3);

        // R9: a load blocks a simultaneous exchange request.
        ld_valid = 1'b1; ld_src = 4'd5; ld_site = 4'd5;
        swp_valid = 1'b1; swp_cur = 4'd10; swp_dst = 4'd11;
        #1;
        chk(swp_ready == 0, "R9 swp_ready low under load", swp_ready, 0);
        @(posedge clk);
        @(negedge clk);
        ld_valid = 1'b0; swp_valid = 1'b0;
        chk(spk_ready == 1, "R9 exchange not started", spk_ready, 1);
        send_spike(4'd10, ov, st);
        chk(ov == 1 && st == 4'd10, "R9 mapping unchanged", st, 10);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule